// File: doc/BRIEF.md
# Converter Launch Sequencer with Settling Lockout

This block sits between a processor's control registers and a successive-approximation converter core. It decides when the core may begin a conversion. It also latches the returned code as a clamped 10-bit result and raises a completion flag and interrupt. The interrupt also serves as the wake request for a halted processor.

Changing a differential input pair or the reference selection starts a lockout. The lockout lasts a fixed number of system clock cycles, computed from the clock frequency and rounded up to cover 125 µs. No conversion begins while the lockout runs. A software start that arrives during the lockout waits and is launched as soon as the lockout ends.

The block can also start a conversion by itself when the processor halts in a low-noise or idle sleep. This happens only when the control bits are in one exact combination at the moment of the halt. A competing wake source cancels that automatic start. The result word is split into a low byte and a high byte, and reading the low byte freezes the pair so that both bytes always come from the same conversion.

Top module: `adc_conv_seq`

## Requirements
- R1: After reset, `conv_start`, `settling`, `start_status`, `done_flag` and `irq` are 0, and the result reads 0.
- R2: A `sel_wr` starts the lockout when either the old or the new channel is differential (code >= DIFF_FIRST), or when `sel_ref` differs from the stored reference. `settling` is then high for exactly SETTLE_CYC cycles, and a new trigger during the lockout restarts the count. A write from one single-ended channel to another with an unchanged reference leaves `settling` low.
- R3: `conv_start` never rises in the cycle after a cycle with `settling` high. A start that is pending during the lockout pulses `conv_start` one cycle after `settling` falls. `start_status` stays 1 until that conversion completes.
- R4: With `en`=1 and no lockout, a `start_wr` sets `start_status` on the next edge, and `conv_start` pulses for one cycle on the edge after that.
- R5: A sleep launch is armed when `cpu_halted` rises while `en`=1, `start_status`=0, `freerun`=0 and `irq_en`=1. The armed launch pulses `conv_start` one cycle after arming. With any other combination of those bits, no conversion begins.
- R6: An `other_wake` pulse while a sleep launch is armed and not yet launched cancels it, and no conversion starts during that sleep.
- R7: `conv_done` during a conversion sets `done_flag` on the same edge. `irq` equals `done_flag` AND `irq_en`, and it is the wake request.
- R8: A `flag_clr` pulse or an `irq_ack` pulse clears `done_flag`. A completion in the same cycle wins over the clear.
- R9: The result is `conv_code` clamped to 0 when the code is negative and to 0x3FF when it is above 1023. `result_lo` carries bits 7:0 and `result_hi` carries bits 9:8.
- R10: A `rd_lo` pulse freezes the result. A completion that arrives while the result is frozen is held back. A `rd_hi` pulse releases the freeze and shows the newest held result.
- R11: With `freerun`=1, each completion relaunches a conversion one cycle later. After `freerun` is cleared, the conversion in progress is the last one, and `start_status` returns to 0 when it completes.
- R12: With `en`=0, `start_wr` is ignored: no `conv_start` pulse and `start_status` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_wr | input | 1 | Write strobe for channel and reference selection |
| sel_chan | input | CH_W | Channel selection; codes >= DIFF_FIRST are differential |
| sel_ref | input | REF_W | Reference selection |
| en | input | 1 | Converter enable |
| freerun | input | 1 | Continuous conversion mode |
| irq_en | input | 1 | Interrupt enable |
| start_wr | input | 1 | Software start request pulse |
| flag_clr | input | 1 | Write-one-to-clear pulse for the completion flag |
| irq_ack | input | 1 | Interrupt acknowledge pulse |
| cpu_halted | input | 1 | Processor halted in low-noise or idle sleep |
| other_wake | input | 1 | A different wake source fired |
| rd_lo | input | 1 | Low result byte read pulse |
| rd_hi | input | 1 | High result byte read pulse |
| conv_start | output | 1 | One-cycle launch pulse to the converter core |
| conv_chan | output | CH_W | Channel presented to the core |
| conv_done | input | 1 | Core completion pulse |
| conv_code | input | RAW_W | Signed raw code from the core |
| settling | output | 1 | Lockout running |
| start_status | output | 1 | Start bit (pending or converting) |
| done_flag | output | 1 | Completion flag |
| irq | output | 1 | Interrupt and wake request |
| result_lo | output | 8 | Result bits 7:0 |
| result_hi | output | RES_W-8 | Result bits 9:8 |

## Verification
All inputs change on the falling edge and all outputs are sampled on the falling edge, so each count below is in rising edges. A software start shows in `start_status` one edge later, and `conv_start` follows one edge after that. A sleep launch appears two edges after `cpu_halted` rises. After a triggering selection write, `settling` reads high at the next SETTLE_CYC samples, and a pending start appears at sample SETTLE_CYC+1. The flag, `irq` and the clamped result are sampled at the falling edge that ends the completion pulse, one edge after `conv_done` was seen. Cancellation and ignored-start cases are checked by counting `conv_start` pulses over a fixed window.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

   // Cycles needed to cover a window of ns nanoseconds at hz, rounded up.
   function automatic longint settle_cycles(input longint hz, input longint ns);
      return (hz * ns + 64'd999_999_999) / 64'd1_000_000_000;
   endfunction

endpackage

// File: rtl/adc_settle_timer.sv
module adc_settle_timer #(
   parameter int CYC = 6250
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trig,
   output logic busy
);

   if (CYC < 0) begin : g_bad
      $error("adc_settle_timer: CYC must not be negative");
   end

   if (CYC == 0) begin : g_none
      assign busy = 1'b0;
   end else begin : g_count
      localparam int CW = $clog2(CYC + 1);
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk) begin
         if (!rst_n)
            cnt_q <= '0;
         else if (trig)
            cnt_q <= CW'(CYC);
         else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
      end

      assign busy = (cnt_q != '0);

      // R2
      settle_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
         trig |=> busy);
   end

endmodule

// File: rtl/adc_result_latch.sv
module adc_result_latch #(
   parameter int RES_W = 10,
   parameter int RAW_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             upd,
   input  logic [RAW_W-1:0] raw,
   input  logic             rd_lo,
   input  logic             rd_hi,
   output logic [RES_W-1:0] res
);

   if (RAW_W < RES_W + 2) begin : g_bad
      $error("adc_result_latch: RAW_W must exceed RES_W by at least 2");
   end

   logic [RES_W-1:0] clamped;
   logic [RES_W-1:0] res_q, shadow_q;
   logic             shad_v_q, lock_q;

   // Negative codes saturate low; codes beyond full scale saturate high.
   always_comb begin
      if (raw[RAW_W-1])
         clamped = '0;
      else if (|raw[RAW_W-2:RES_W])
         clamped = '1;
      else
         clamped = raw[RES_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_q    <= '0;
         shadow_q <= '0;
         shad_v_q <= 1'b0;
         lock_q   <= 1'b0;
      end else begin
         if (rd_lo)
            lock_q <= 1'b1;
         if (rd_hi) begin
            lock_q <= 1'b0;
            if (shad_v_q) begin
               res_q    <= shadow_q;
               shad_v_q <= 1'b0;
            end
         end
         if (upd) begin
            if ((lock_q || rd_lo) && !rd_hi) begin
               shadow_q <= clamped;
               shad_v_q <= 1'b1;
            end else begin
               res_q    <= clamped;
               shad_v_q <= 1'b0;
            end
         end
      end
   end

   assign res = res_q;

   // R10
   hold_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_q && !rd_hi) |=> $stable(res_q));

endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq #(
   parameter int CLK_HZ     = 50_000_000,
   parameter int SETTLE_NS  = 125_000,
   parameter int CH_W       = 5,
   parameter int REF_W      = 2,
   parameter int DIFF_FIRST = 11,
   parameter int RES_W      = 10,
   parameter int RAW_W      = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sel_wr,
   input  logic [CH_W-1:0]  sel_chan,
   input  logic [REF_W-1:0] sel_ref,
   input  logic             en,
   input  logic             freerun,
   input  logic             irq_en,
   input  logic             start_wr,
   input  logic             flag_clr,
   input  logic             irq_ack,
   input  logic             cpu_halted,
   input  logic             other_wake,
   input  logic             rd_lo,
   input  logic             rd_hi,
   output logic             conv_start,
   output logic [CH_W-1:0]  conv_chan,
   input  logic             conv_done,
   input  logic [RAW_W-1:0] conv_code,
   output logic             settling,
   output logic             start_status,
   output logic             done_flag,
   output logic             irq,
   output logic [7:0]       result_lo,
   output logic [RES_W-9:0] result_hi
);

   localparam longint SETTLE_L =
      adc_seq_pkg::settle_cycles(longint'(CLK_HZ), longint'(SETTLE_NS));
   localparam int SETTLE_CYC = int'(SETTLE_L);

   if (RES_W < 9 || RES_W > 16) begin : g_bad_res
      $error("adc_conv_seq: RES_W must lie in 9..16");
   end
   if (DIFF_FIRST >= (1 << CH_W)) begin : g_bad_diff
      $error("adc_conv_seq: DIFF_FIRST out of channel range");
   end

   logic [CH_W-1:0]  chan_q;
   logic [REF_W-1:0] ref_q;
   logic halted_q, start_q, busy_q, armed_q, flag_q, cstart_q;
   logic trig, launch, done_ok, halt_rise, arm_ok;
   logic [RES_W-1:0] res;

   // Lockout trigger: a differential pair on either side, or a new reference.
   assign trig = sel_wr && ((sel_chan >= CH_W'(DIFF_FIRST)) ||
                            (chan_q   >= CH_W'(DIFF_FIRST)) ||
                            (sel_ref  != ref_q));

   adc_settle_timer #(.CYC(SETTLE_CYC)) i_settle (
      .clk  (clk),
      .rst_n(rst_n),
      .trig (trig),
      .busy (settling)
   );

   assign halt_rise = cpu_halted && !halted_q;
   assign arm_ok    = en && !start_q && !freerun && irq_en;
   assign done_ok   = conv_done && busy_q;
   assign launch    = en && !busy_q && !settling &&
                      (start_q || (armed_q && !other_wake));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chan_q   <= '0;
         ref_q    <= '0;
         halted_q <= 1'b0;
         start_q  <= 1'b0;
         busy_q   <= 1'b0;
         armed_q  <= 1'b0;
         flag_q   <= 1'b0;
         cstart_q <= 1'b0;
      end else begin
         if (sel_wr) begin
            chan_q <= sel_chan;
            ref_q  <= sel_ref;
         end
         halted_q <= cpu_halted;
         cstart_q <= launch;

         if (launch)
            busy_q <= 1'b1;
         else if (done_ok)
            busy_q <= 1'b0;

         if (done_ok)
            start_q <= freerun && en;
         if (start_wr && en)
            start_q <= 1'b1;
         if (!en && !busy_q)
            start_q <= 1'b0;

         if (launch || other_wake || !cpu_halted)
            armed_q <= 1'b0;
         if (halt_rise && arm_ok)
            armed_q <= 1'b1;

         if (flag_clr || irq_ack)
            flag_q <= 1'b0;
         if (done_ok)
            flag_q <= 1'b1;
      end
   end

   adc_result_latch #(.RES_W(RES_W), .RAW_W(RAW_W)) i_result (
      .clk  (clk),
      .rst_n(rst_n),
      .upd  (done_ok),
      .raw  (conv_code),
      .rd_lo(rd_lo),
      .rd_hi(rd_hi),
      .res  (res)
   );

   assign conv_start   = cstart_q;
   assign conv_chan    = chan_q;
   assign start_status = start_q;
   assign done_flag    = flag_q;
   assign irq          = flag_q && irq_en;
   assign result_lo    = res[7:0];
   assign result_hi    = res[RES_W-1:8];

   // R3
   no_start_in_settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      settling |=> !conv_start);

   // R7
   flag_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_ok |=> done_flag);

   // R12
   disabled_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !conv_start);

   // R4
   single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |=> !conv_start);

endmodule

// File: tb/test_adc_conv_seq.sv
module test_adc_conv_seq;

   localparam int CLK_HZ = 200_000;
   localparam int S      = 25;
   localparam int LAT    = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sel_wr = 0, en = 0, freerun = 0, irq_en = 0, start_wr = 0;
   logic flag_clr = 0, irq_ack = 0, cpu_halted = 0, other_wake = 0;
   logic rd_lo = 0, rd_hi = 0, conv_done = 0;
   logic [4:0]  sel_chan = '0;
   logic [1:0]  sel_ref = '0;
   logic [11:0] conv_code = '0;
   logic        conv_start, settling, start_status, done_flag, irq;
   logic [4:0]  conv_chan;
   logic [7:0]  result_lo;
   logic [1:0]  result_hi;

   int checks = 0, failures = 0, n_starts = 0, cyc = 0, next_code = 0;
   logic prev_settle = 1'b0;

   always #10 clk = ~clk;

   adc_conv_seq #(.CLK_HZ(CLK_HZ)) i_adc_conv_seq (
      .clk(clk), .rst_n(rst_n), .sel_wr(sel_wr), .sel_chan(sel_chan),
      .sel_ref(sel_ref), .en(en), .freerun(freerun), .irq_en(irq_en),
      .start_wr(start_wr), .flag_clr(flag_clr), .irq_ack(irq_ack),
      .cpu_halted(cpu_halted), .other_wake(other_wake), .rd_lo(rd_lo),
      .rd_hi(rd_hi), .conv_start(conv_start), .conv_chan(conv_chan),
      .conv_done(conv_done), .conv_code(conv_code), .settling(settling),
      .start_status(start_status), .done_flag(done_flag), .irq(irq),
      .result_lo(result_lo), .result_hi(result_hi)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s act=%0d exp=%0d", req, act, exp);
      end
   endtask

   function automatic int clamp(input int c);
      if (c < 0) return 0;
      if (c > 1023) return 1023;
      return c;
   endfunction

   // Converter core model.
   initial begin
      forever begin
         @(negedge clk);
         if (conv_start) begin
            repeat (LAT) @(negedge clk);
            conv_code = 12'(next_code);
            conv_done = 1'b1;
            @(negedge clk);
            conv_done = 1'b0;
         end
      end
   end

   // Launch monitor: R3 lockout never bypassed.
   always @(negedge clk) begin
      cyc++;
      if (conv_start) begin
         n_starts++;
         check("R3 launch after lockout", int'(prev_settle), 0);
      end
      prev_settle <= settling;
      if (cyc > 150000) begin
         failures++;
         $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic wait_flag(input string req);
      int n = 0;
      while (!done_flag && n < 300) begin
         @(negedge clk);
         n++;
      end
      check(req, int'(done_flag), 1);
   endtask

   task automatic sw_convert(input int code);
      next_code = code;
      start_wr = 1'b1;
      @(negedge clk);
      start_wr = 1'b0;
      wait_flag("R7 flag set on completion");
   endtask

   task automatic clear_flag();
      flag_clr = 1'b1;
      @(negedge clk);
      flag_clr = 1'b0;
   endtask

   task automatic write_sel(input int ch, input int rf);
      sel_chan = 5'(ch);
      sel_ref  = 2'(rf);
      sel_wr   = 1'b1;
      @(negedge clk);
      sel_wr   = 1'b0;
   endtask

   initial begin
      int corner [6] = '{-1, 0, 1023, 1024, 2047, -1024};
      int m, base, cnt;
      void'($urandom(32'd20240611));

      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 conv_start", int'(conv_start), 0);
      check("R1 settling", int'(settling), 0);
      check("R1 start_status", int'(start_status), 0);
      check("R1 done_flag", int'(done_flag), 0);
      check("R1 irq", int'(irq), 0);
      check("R1 result", int'({result_hi, result_lo}), 0);

      en = 1'b1;
      irq_en = 1'b1;

      // R2: single-ended to single-ended, same reference
      write_sel(3, 0);
      check("R2 no lockout single-ended", int'(settling), 0);

      // R4, R9, R7, R8: corner and random codes
      for (int i = 0; i < 14; i++) begin
         int code = (i < 6) ? corner[i] : int'($urandom_range(0, 3071)) - 1024;
         next_code = code;
         start_wr = 1'b1;
         @(negedge clk);
         start_wr = 1'b0;
         check("R4 start_status set", int'(start_status), 1);
         check("R4 no launch yet", int'(conv_start), 0);
         @(negedge clk);
         check("R4 launch pulse", int'(conv_start), 1);
         wait_flag("R7 flag set on completion");
         check("R9 clamped result", int'({result_hi, result_lo}), clamp(code));
         check("R9 high byte", int'(result_hi), clamp(code) >> 8);
         check("R7 irq follows flag", int'(irq), 1);
         check("R3 start_status cleared", int'(start_status), 0);
         clear_flag();
         check("R8 flag_clr clears", int'(done_flag), 0);
      end

      // R2/R3: differential select with a start in the same cycle
      next_code = 321;
      sel_chan = 5'd12;
      sel_wr = 1'b1;
      start_wr = 1'b1;
      @(negedge clk);
      sel_wr = 1'b0;
      start_wr = 1'b0;
      m = 0;
      check("R2 lockout begins", int'(settling), 1);
      while (!conv_start && m < 200) begin
         if (m == S - 1) check("R2 still settling", int'(settling), 1);
         if (m == S)     check("R2 lockout ended", int'(settling), 0);
         check("R3 start pending", int'(start_status), 1);
         @(negedge clk);
         m++;
      end
      check("R3 pending launch cycle", m, S + 1);
      wait_flag("R7 flag after pending start");
      check("R9 result after lockout", int'({result_hi, result_lo}), 321);
      clear_flag();

      // R2 restart by a rewrite during the lockout
      write_sel(13, 0);
      repeat (9) @(negedge clk);
      write_sel(12, 0);
      cnt = 0;
      while (settling && cnt < 200) begin
         cnt++;
         @(negedge clk);
      end
      check("R2 restarted window length", cnt, S);

      // R2: differential to single-ended triggers; then reference change
      write_sel(3, 0);
      check("R2 leaving differential", int'(settling), 1);
      repeat (S + 2) @(negedge clk);
      write_sel(3, 1);
      check("R2 reference change", int'(settling), 1);
      repeat (S + 2) @(negedge clk);
      write_sel(3, 1);
      check("R2 same reference no lockout", int'(settling), 0);

      // R8: interrupt acknowledge; R7 with irq_en low
      sw_convert(77);
      irq_ack = 1'b1;
      @(negedge clk);
      irq_ack = 1'b0;
      check("R8 irq_ack clears", int'(done_flag), 0);
      irq_en = 1'b0;
      sw_convert(78);
      check("R7 irq masked", int'(irq), 0);
      irq_en = 1'b1;
      #1;
      check("R7 irq unmasked", int'(irq), 1);
      clear_flag();

      // R5: sleep-triggered launch
      next_code = 600;
      cpu_halted = 1'b1;
      @(negedge clk);
      check("R5 armed, not launched", int'(conv_start), 0);
      @(negedge clk);
      check("R5 sleep launch", int'(conv_start), 1);
      wait_flag("R7 flag after sleep launch");
      check("R7 wake request", int'(irq), 1);
      check("R9 sleep result", int'({result_hi, result_lo}), 600);
      cpu_halted = 1'b0;
      clear_flag();

      // R5: wrong combination does not arm
      irq_en = 1'b0;
      base = n_starts;
      cpu_halted = 1'b1;
      repeat (20) @(negedge clk);
      check("R5 no arm with irq_en low", n_starts - base, 0);
      cpu_halted = 1'b0;
      irq_en = 1'b1;
      @(negedge clk);

      // R6: competing wake cancels
      base = n_starts;
      cpu_halted = 1'b1;
      @(negedge clk);
      other_wake = 1'b1;
      @(negedge clk);
      other_wake = 1'b0;
      repeat (20) @(negedge clk);
      check("R6 cancelled launch", n_starts - base, 0);
      cpu_halted = 1'b0;
      @(negedge clk);

      // R10: read lock
      sw_convert(100);
      clear_flag();
      rd_lo = 1'b1;
      @(negedge clk);
      rd_lo = 1'b0;
      sw_convert(900);
      check("R10 frozen while locked", int'({result_hi, result_lo}), 100);
      rd_hi = 1'b1;
      @(negedge clk);
      rd_hi = 1'b0;
      check("R10 newest after release", int'({result_hi, result_lo}), 900);
      clear_flag();
      sw_convert(500);
      check("R10 unlocked update", int'({result_hi, result_lo}), 500);
      clear_flag();

      // R11: free-run
      freerun = 1'b1;
      next_code = 42;
      base = n_starts;
      start_wr = 1'b1;
      @(negedge clk);
      start_wr = 1'b0;
      repeat (40) @(negedge clk);
      check("R11 repeated launches", int'((n_starts - base) >= 3), 1);
      check("R11 start_status held", int'(start_status), 1);
      freerun = 1'b0;
      cnt = 0;
      while (start_status && cnt < 100) begin
         cnt++;
         @(negedge clk);
      end
      check("R11 start_status drops", int'(start_status), 0);
      base = n_starts;
      repeat (20) @(negedge clk);
      check("R11 no further launch", n_starts - base, 0);
      clear_flag();

      // R12: disabled start ignored
      en = 1'b0;
      base = n_starts;
      start_wr = 1'b1;
      @(negedge clk);
      start_wr = 1'b0;
      check("R12 start_status stays low", int'(start_status), 0);
      repeat (10) @(negedge clk);
      check("R12 no launch when disabled", n_starts - base, 0);
      en = 1'b1;

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule